// File: doc/BRIEF.md
# Two-Wire Register Bank Slave

This block is a slave-only two-wire serial port that gives an external controller access to a small bank of 8-bit control registers. The SCL and SDA lines pass through a synchronizer on the system clock. Start and stop conditions are taken from SDA edges while SCL is high, and each byte is shifted MSB first on SCL edges. SDA is never driven high. The block drives it only through an active-high enable that pulls the line low.

An internal byte pointer selects the register for each access. In a write transaction, the first byte after the device address loads the pointer. Every later byte is stored at the pointer, and the pointer then advances. In a read, the block sends the register at the pointer and advances the pointer, so a read with no address phase continues from the last access plus one. To read a chosen address, the controller sends a pointer-setting write, issues a repeated start, and then reads. When a stop closes a sequence that contained a read, a standby output is raised. The next start clears it. The register contents are brought out in parallel so that the controlled logic can use them.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The block acknowledges only a device-address byte whose upper seven bits are 0110110 (0x6C for a write, 0x6D for a read, with bit 0 as the read flag). Any other address byte gets no acknowledge, and the block stays silent until the next start.
- R2: SDA falling while SCL is high is a start. SDA rising while SCL is high is a stop. A start, including a repeated start, always restarts address matching, whatever state the transfer was in.
- R3: The block pulls SDA low during the ninth clock of every byte it receives when the address has matched, including pointer and data bytes.
- R4: In a write transaction, the first byte after the address loads the pointer. Each later byte is written to the register at the pointer, and the pointer then increments.
- R5: A read sends the register at the pointer MSB first, with one bit per SCL clock, starting right after the address acknowledge.
- R6: The pointer keeps the last accessed address plus one across transactions, so a read with no address phase returns the next register.
- R7: During a read, a controller acknowledge (SDA low on the ninth clock) makes the block send the next register. A controller no-acknowledge ends the read.
- R8: A stop that ends a sequence containing a read raises standby_o. A stop after a write-only sequence does not raise it. Any start clears it.
- R9: After reset, registers 0x00, 0x01 and 0x02 hold 0x5C, 0xC3 and 0x40, the pointer is 0, and standby_o and sda_oe are low.
- R10: A write to an address at or beyond NUM_REGS is acknowledged and discarded. A read from such an address returns 0x00.
- R11: sda_oe changes only while SCL is low, so the block never creates a start or a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Pulls SDA low when high; the line floats high when low |
| standby_o | output | 1 | Standby request raised by a stop after a read |
| reg_bank_o | output | NUM_REGS*8 | All register contents, register n at bits 8n+7:8n |

## Verification
The bench uses the default parameters: three registers, an 8-bit pointer and a two-stage synchronizer. With only three registers, one sequential read runs the pointer from a defined address into undefined space. Pointer value 0x10 also lies well outside the bank. Together these reach the discard and zero-read paths within a few transactions. Each bit phase lasts eight system clocks, which is longer than the synchronizer delay plus the edge-detect delay. Every acknowledge and data bit is therefore driven before SCL rises.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WR,
      ST_WACK,
      ST_RD,
      ST_MACK
   } xfer_st_t;

   // Power-on contents of the register bank
   function automatic logic [7:0] reg_default(input int idx);
      logic [7:0] val;
      case (idx)
         0:       val = 8'h5C;
         1:       val = 8'hC3;
         2:       val = 8'h40;
         default: val = 8'h00;
      endcase
      return val;
   endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int LINES  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] line_i,
   output logic [LINES-1:0] line_q,
   output logic [LINES-1:0] line_d
);

   for (genvar l = 0; l < LINES; l++) begin : g_line
      logic [STAGES-1:0] chain;
      logic              hist;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '1;
            hist  <= 1'b1;
         end else begin
            chain <= {chain[STAGES-2:0], line_i[l]};
            hist  <= chain[STAGES-1];
         end
      end

      assign line_q[l] = chain[STAGES-1];
      assign line_d[l] = hist;
   end

endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
   input  logic scl_q,
   input  logic scl_d,
   input  logic sda_q,
   input  logic sda_d,
   output logic start_det,
   output logic stop_det,
   output logic scl_rise,
   output logic scl_fall
);

   logic scl_held;

   always_comb begin
      scl_held  = scl_q & scl_d;
      start_det = scl_held & sda_d & ~sda_q;
      stop_det  = scl_held & ~sda_d & sda_q;
      scl_rise  = scl_q & ~scl_d;
      scl_fall  = ~scl_q & scl_d;
   end

endmodule

// File: rtl/i2c_reg_file.sv
module i2c_reg_file
   import i2c_rb_pkg::*;
#(
   parameter int NUM_REGS = 3,
   parameter int ADDR_W   = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [ADDR_W-1:0]     waddr,
   input  logic [7:0]            wdata,
   input  logic [ADDR_W-1:0]     raddr,
   output logic [7:0]            rdata,
   output logic [NUM_REGS*8-1:0] bank_o
);

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [7:0] q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= reg_default(g);
         end else if (we && (waddr == ADDR_W'(g))) begin
            q <= wdata;
         end
      end

      assign bank_o[g*8 +: 8] = q;
   end

   // Addresses outside the bank read as zero
   always_comb begin
      rdata = 8'h00;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (raddr == ADDR_W'(i)) begin
            rdata = bank_o[i*8 +: 8];
         end
      end
   end

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
   import i2c_rb_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h36,
   parameter int         NUM_REGS    = 3,
   parameter int         ADDR_W      = 8,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_oe,
   output logic                  standby_o,
   output logic [NUM_REGS*8-1:0] reg_bank_o
);

   localparam int CNT_W = 4;
   localparam logic [CNT_W-1:0] BYTE_DONE = CNT_W'(8);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr
      $error("ADDR_W must lie in 1..8");
   end
   if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_regs
      $error("NUM_REGS must lie in 1..2**ADDR_W");
   end

   logic [1:0] lines_q, lines_d;
   logic       scl_s, scl_d, sda_s, sda_d;
   logic       start_det, stop_det, scl_rise, scl_fall;

   i2c_line_sync #(
      .LINES  (2),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i ({scl_i, sda_i}),
      .line_q (lines_q),
      .line_d (lines_d)
   );

   assign scl_s = lines_q[1];
   assign sda_s = lines_q[0];
   assign scl_d = lines_d[1];
   assign sda_d = lines_d[0];

   i2c_bus_cond u_cond (
      .scl_q     (scl_s),
      .scl_d     (scl_d),
      .sda_q     (sda_s),
      .sda_d     (sda_d),
      .start_det (start_det),
      .stop_det  (stop_det),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall)
   );

   xfer_st_t           state;
   logic [CNT_W-1:0]   bit_cnt;
   logic [7:0]         shreg;
   logic [ADDR_W-1:0]  ptr;
   logic               ptr_phase;
   logic               rw_q;
   logic               rd_seen;
   logic               rd_more;
   logic               wr_en;
   logic [7:0]         rd_data;
   logic               byte_end;

   assign byte_end = scl_fall && (bit_cnt == BYTE_DONE);
   assign wr_en    = (state == ST_WR) && byte_end && !ptr_phase
                     && !start_det && !stop_det;

   i2c_reg_file #(
      .NUM_REGS (NUM_REGS),
      .ADDR_W   (ADDR_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (wr_en),
      .waddr  (ptr),
      .wdata  (shreg),
      .raddr  (ptr),
      .rdata  (rd_data),
      .bank_o (reg_bank_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bit_cnt   <= '0;
         shreg     <= '0;
         ptr       <= '0;
         ptr_phase <= 1'b0;
         rw_q      <= 1'b0;
         rd_seen   <= 1'b0;
         rd_more   <= 1'b0;
         sda_oe    <= 1'b0;
         standby_o <= 1'b0;
      end else if (start_det) begin
         state     <= ST_ADDR;
         bit_cnt   <= '0;
         sda_oe    <= 1'b0;
         standby_o <= 1'b0;
         rd_seen   <= 1'b0;
      end else if (stop_det) begin
         state   <= ST_IDLE;
         sda_oe  <= 1'b0;
         rd_seen <= 1'b0;
         if (rd_seen) begin
            standby_o <= 1'b1;
         end
      end else begin
         case (state)
            ST_ADDR: begin
               if (scl_rise) begin
                  shreg   <= {shreg[6:0], sda_s};
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (byte_end) begin
                  if (shreg[7:1] == DEV_ADDR) begin
                     state  <= ST_AACK;
                     sda_oe <= 1'b1;
                     rw_q   <= shreg[0];
                     if (shreg[0]) begin
                        rd_seen <= 1'b1;
                     end
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_AACK: begin
               if (scl_fall) begin
                  bit_cnt <= '0;
                  if (rw_q) begin
                     state  <= ST_RD;
                     shreg  <= rd_data;
                     sda_oe <= ~rd_data[7];
                     ptr    <= ptr + 1'b1;
                  end else begin
                     state     <= ST_WR;
                     sda_oe    <= 1'b0;
                     ptr_phase <= 1'b1;
                  end
               end
            end
            ST_WR: begin
               if (scl_rise) begin
                  shreg   <= {shreg[6:0], sda_s};
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (byte_end) begin
                  state  <= ST_WACK;
                  sda_oe <= 1'b1;
                  if (ptr_phase) begin
                     ptr       <= shreg[ADDR_W-1:0];
                     ptr_phase <= 1'b0;
                  end else begin
                     ptr <= ptr + 1'b1;
                  end
               end
            end
            ST_WACK: begin
               if (scl_fall) begin
                  state   <= ST_WR;
                  sda_oe  <= 1'b0;
                  bit_cnt <= '0;
               end
            end
            ST_RD: begin
               if (scl_rise) begin
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (scl_fall) begin
                  if (bit_cnt == BYTE_DONE) begin
                     state  <= ST_MACK;
                     sda_oe <= 1'b0;
                  end else begin
                     sda_oe <= ~shreg[6];
                     shreg  <= {shreg[6:0], 1'b0};
                  end
               end
            end
            ST_MACK: begin
               if (scl_rise) begin
                  rd_more <= ~sda_s;
               end else if (scl_fall) begin
                  bit_cnt <= '0;
                  if (rd_more) begin
                     state  <= ST_RD;
                     shreg  <= rd_data;
                     sda_oe <= ~rd_data[7];
                     ptr    <= ptr + 1'b1;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: begin
               state <= ST_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/i2c_regbank_slave_chk.sv
module i2c_regbank_slave_chk
   import i2c_rb_pkg::*;
#(
   parameter int BANK_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_s,
   input logic              sda_oe,
   input logic              standby_o,
   input logic              start_det,
   input logic              stop_det,
   input logic [BANK_W-1:0] reg_bank_o,
   input xfer_st_t          state
);

   AST_OE_QUIET_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s)) |-> $stable(sda_oe)); // R11

   AST_STANDBY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(standby_o) |-> $past(stop_det)); // R8

   AST_START_CLEARS_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !standby_o); // R8

   AST_STANDBY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      standby_o |-> !sda_oe); // R8

   AST_BANK_CHANGE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(reg_bank_o) |-> (state == ST_WACK)); // R4

   AST_NO_DRIVE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe); // R2

endmodule

bind i2c_regbank_slave i2c_regbank_slave_chk #(
   .BANK_W (NUM_REGS*8)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .scl_s      (scl_s),
   .sda_oe     (sda_oe),
   .standby_o  (standby_o),
   .start_det  (start_det),
   .stop_det   (stop_det),
   .reg_bank_o (reg_bank_o),
   .state      (state)
);

// File: tb/i2c_regbank_slave_tb.sv
module i2c_regbank_slave_tb;

   localparam int Q = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic        sda_line;
   logic        sda_oe;
   logic        standby_o;
   logic [23:0] reg_bank_o;

   int n_chk = 0;
   int n_bad = 0;
   int oe_viol = 0;
   int scl_hi_cnt = 0;
   logic prev_oe = 1'b0;

   always #2 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   i2c_regbank_slave u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_m),
      .sda_i      (sda_line),
      .sda_oe     (sda_oe),
      .standby_o  (standby_o),
      .reg_bank_o (reg_bank_o)
   );

   // R11 monitor: drive enable must not move while SCL has been high a while
   always @(negedge clk) begin
      if (rst_n && scl_m && scl_hi_cnt >= 4 && sda_oe != prev_oe) oe_viol++;
      scl_hi_cnt = scl_m ? scl_hi_cnt + 1 : 0;
      prev_oe = sda_oe;
   end

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic wait_q();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_q();
      scl_m = 1'b1; wait_q();
      sda_m = 1'b0; wait_q();
      scl_m = 1'b0;
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_q();
      scl_m = 1'b1; wait_q();
      sda_m = 1'b1; wait_q(); wait_q();
   endtask

   task automatic put_bit(input logic b, output logic seen);
      wait_q(); sda_m = b;
      wait_q(); scl_m = 1'b1;
      wait_q(); seen = sda_line;
      wait_q(); scl_m = 1'b0;
   endtask

   task automatic wr_byte(input logic [7:0] d, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) put_bit(d[i], s);
      put_bit(1'b1, ack);
   endtask

   task automatic rd_byte(input logic master_ack, output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         put_bit(1'b1, s);
         d[i] = s;
      end
      put_bit(~master_ack, s);
   endtask

   function automatic logic [7:0] reg_of(input int i);
      return reg_bank_o[i*8 +: 8];
   endfunction

   task automatic t_reset();
      chk("R9 reg0 default", reg_of(0), 8'h5C);
      chk("R9 reg1 default", reg_of(1), 8'hC3);
      chk("R9 reg2 default", reg_of(2), 8'h40);
      chk("R9 standby low", {7'b0, standby_o}, 8'h00);
      chk("R9 sda_oe low", {7'b0, sda_oe}, 8'h00);
   endtask

   task automatic t_mismatch();
      logic a;
      bus_start();
      wr_byte(8'h50, a);
      chk("R1 foreign address not acked", {7'b0, a}, 8'h01);
      wr_byte(8'h00, a);
      chk("R1 silent after mismatch", {7'b0, a}, 8'h01);
      bus_start();
      wr_byte(8'h6C, a);
      chk("R2 repeated start rematches", {7'b0, a}, 8'h00);
      bus_stop();
   endtask

   task automatic t_write();
      logic a;
      bus_start();
      wr_byte(8'h6C, a); chk("R1 write address acked", {7'b0, a}, 8'h00);
      wr_byte(8'h00, a); chk("R3 pointer byte acked", {7'b0, a}, 8'h00);
      wr_byte(8'hA5, a); chk("R3 data byte acked", {7'b0, a}, 8'h00);
      wr_byte(8'h3C, a);
      bus_stop();
      chk("R4 reg0 written", reg_of(0), 8'hA5);
      chk("R4 reg1 written after increment", reg_of(1), 8'h3C);
      chk("R4 reg2 untouched", reg_of(2), 8'h40);
      chk("R8 no standby after write", {7'b0, standby_o}, 8'h00);
   endtask

   task automatic t_random_read();
      logic a;
      logic [7:0] d;
      bus_start();
      wr_byte(8'h6C, a);
      wr_byte(8'h01, a);
      bus_start();
      wr_byte(8'h6D, a); chk("R1 read address acked", {7'b0, a}, 8'h00);
      rd_byte(1'b0, d);
      chk("R5 random read reg1", d, 8'h3C);
      bus_stop();
      chk("R8 standby after read stop", {7'b0, standby_o}, 8'h01);
   endtask

   task automatic t_current_read();
      logic a;
      logic [7:0] d;
      bus_start();
      chk("R8 start clears standby", {7'b0, standby_o}, 8'h00);
      wr_byte(8'h6D, a);
      rd_byte(1'b0, d);
      chk("R6 current read continues at reg2", d, 8'h40);
      bus_stop();
      bus_start();
      wr_byte(8'h6D, a);
      rd_byte(1'b0, d);
      chk("R10 undefined address reads zero", d, 8'h00);
      bus_stop();
   endtask

   task automatic t_seq_read();
      logic a;
      logic [7:0] d;
      bus_start();
      wr_byte(8'h6C, a);
      wr_byte(8'h00, a);
      bus_start();
      wr_byte(8'h6D, a);
      rd_byte(1'b1, d); chk("R7 sequential byte 0", d, 8'hA5);
      rd_byte(1'b1, d); chk("R7 sequential byte 1", d, 8'h3C);
      rd_byte(1'b0, d); chk("R7 sequential byte 2", d, 8'h40);
      bus_stop();
      bus_start();
      wr_byte(8'h6D, a);
      rd_byte(1'b0, d);
      chk("R7 no-ack ended read, pointer at 3", d, 8'h00);
      bus_stop();
   endtask

   task automatic t_undef_write();
      logic a;
      bus_start();
      wr_byte(8'h6C, a);
      wr_byte(8'h10, a);
      wr_byte(8'h77, a);
      chk("R10 undefined write acked", {7'b0, a}, 8'h00);
      bus_stop();
      chk("R10 reg0 unchanged", reg_of(0), 8'hA5);
      chk("R10 reg1 unchanged", reg_of(1), 8'h3C);
      chk("R10 reg2 unchanged", reg_of(2), 8'h40);
   endtask

   bit done = 1'b0;

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_mismatch();
      t_write();
      t_random_read();
      t_current_read();
      t_seq_read();
      t_undef_write();
      chk("R11 drive changes only with SCL low", 8'(oe_viol), 8'h00);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule